// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Emulator

This block imitates the read side of an asynchronous parallel NOR flash in synchronous logic. A host drives chip enable, output enable, write enable, an address bus and a write-data bus. The block returns data together with a drive flag that stands in for a tri-state bus. A strap input picks a 16-bit or an 8-bit data bus. All delays are counted in clock cycles.

When a new page is opened, the block senses every word of the page into a page buffer. It then waits a long initial delay before it shows the first word, which is the word at the address that opened the page. Later reads that stay inside the page come from the buffer after a short delay and may be made in any order. A volatile setting chooses a 4-word or an 8-word page. The setting is changed by a two-write command, and reset returns it to 4 words.

The array behind the buffer holds a computed pattern, so any host or bench can predict every word without a loaded memory image.

Top module: `pflash_page_reader`

## Requirements
- R1: `dq_oe` is 1 only while `rst_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, and only once the delays below have run out. Whenever `dq_oe` is 0, `dq_out` reads 0. Raising `oe_n` alone turns the output off in the same cycle. Lowering `oe_n` again on a loaded page brings the data back with no new delay.
- R2: While `rst_n` is 0, `dq_oe` and `dq_out` are 0.
- R3: A page opens on the first rising edge at which `ce_n`=0 and `we_n`=1 and either no page is loaded or the page-tag address bits differ from the loaded page. Data for the address presented then becomes valid exactly INIT_DLY (default 8) rising edges after that address was applied, and not one edge sooner.
- R4: Inside a loaded page, a change of only the in-page offset bits gives valid data exactly PAGE_DLY (default 2) rising edges later. Offsets may be revisited in any order.
- R5: The word at word index k = `addr[8:1]` is {k ^ 8'hC3, k}. In 4-word mode the tag is `addr[15:3]`, and on the 16-bit bus `addr[2:1]` pick the word while `addr[0]` is ignored.
- R6: With `bus16`=0, the in-page offset also includes `addr[0]`. `addr[0]`=0 returns the low byte of the word and 1 returns the high byte, on `dq_out[7:0]`, with `dq_out[15:8]`=0.
- R7: In 8-word mode the tag is `addr[15:4]` and `addr[3:1]` pick the word, so a change of `addr[3]` is an in-page access (R4). In 4-word mode the same change opens a new page (R3).
- R8: Raising `ce_n` for at least one rising edge drops the loaded page. The next read of even the same address takes the full initial delay.
- R9: A write event is a rising edge with `ce_n`=0 and `we_n`=0 where `we_n` was 1 at the previous edge. A write event carrying `dq_in[7:0]`=8'h5A, followed by a second write event carrying `dq_in[7:0]`=8'hC9, loads the page size from `addr[0]` of the second write (1 = 8 words). Any write cycle drops the loaded page.
- R10: If the write event after 8'h5A carries any code other than 8'hC9, the command is abandoned and the page size keeps its value.
- R11: Reset returns the page size to 4 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that counts all delays |
| rst_n | input | 1 | Active-low reset; also turns the output off |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| bus16 | input | 1 | Width strap: 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Address; A0 is the byte select on the 8-bit bus |
| dq_in | input | 16 | Write data carrying the command code |
| dq_out | output | 16 | Read data, 0 when not driven |
| dq_oe | output | 1 | High while the block would drive the data bus |

## Verification
Every stimulus is applied on a falling clock edge. A new-page read is due on the INIT_DLY-th following rising edge and an in-page read on the PAGE_DLY-th. The bench therefore looks just after the rising edge one before the due edge, expecting the output off, and again just after the due edge, expecting the word. Changes of the enables take effect with no clock, so those checks sample one time unit after the falling edge that made the change. A page-size change is observed only through the delay of the first read that crosses an `addr[3]` boundary after the two writes.

// File: rtl/pflash_page_reader.sv
module pflash_page_reader #(
  parameter int ADDR_W = 16,
  parameter int INIT_DLY = 8,
  parameter int PAGE_DLY = 2,
  parameter logic [7:0] SET_CODE = 8'h5A,
  parameter logic [7:0] CONF_CODE = 8'hC9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              bus16,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe
);
  localparam int IW = $clog2(INIT_DLY + 1);
  localparam int PW = $clog2(PAGE_DLY + 1);
  localparam int TW = ADDR_W - 3;
  localparam logic [IW-1:0] I_LOAD = IW'(INIT_DLY - 1);
  localparam logic [PW-1:0] P_LOAD = PW'(PAGE_DLY - 1);

  logic [IW-1:0] icnt;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tag_q;
  logic [3:0]    ofs_q;
  logic          loaded, mode8, cmd_q, we_q;
  logic [15:0]   pbuf [8];

  function automatic logic [15:0] word_at(input logic [7:0] k);
    return {k ^ 8'hC3, k};
  endfunction

  logic rd_cyc, wr_evt, tag_hit, sense;
  logic [3:0] ofs;
  logic [15:0] word_sel;
  logic [7:0]  byte_sel;

  assign rd_cyc   = !ce_n && we_n;
  assign wr_evt   = !ce_n && !we_n && we_q;
  assign tag_hit  = mode8 ? (addr[ADDR_W-1:4] == tag_q[TW-1:1]) : (addr[ADDR_W-1:3] == tag_q);
  assign sense    = rd_cyc && (!loaded || !tag_hit);
  assign ofs      = {mode8 & addr[3], addr[2:1], !bus16 & addr[0]};
  assign word_sel = pbuf[ofs[3:1]];
  assign byte_sel = addr[0] ? word_sel[15:8] : word_sel[7:0];
  assign dq_oe    = rst_n && !ce_n && !oe_n && we_n && loaded && tag_hit &&
                    (ofs == ofs_q) && (icnt == '0) && (pcnt == '0);
  assign dq_out   = !dq_oe ? 16'h0000 : (bus16 ? word_sel : {8'h00, byte_sel});

  always_ff @(posedge clk) begin
    if (sense)
      for (int i = 0; i < 8; i++)
        pbuf[i] <= word_at(mode8 ? {addr[8:4], 3'(i)} : {addr[8:3], 2'(i)});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      tag_q  <= '0;
      ofs_q  <= '0;
      icnt   <= '0;
      pcnt   <= '0;
      mode8  <= 1'b0;
      cmd_q  <= 1'b0;
      we_q   <= 1'b1;
    end else begin
      we_q <= we_n;
      if (sense) begin
        loaded <= 1'b1;
        tag_q  <= addr[ADDR_W-1:3];
        icnt   <= I_LOAD;
        pcnt   <= '0;
        ofs_q  <= ofs;
      end else if (rd_cyc) begin
        if (icnt != '0) icnt <= icnt - 1'b1;
        if (ofs != ofs_q) begin
          ofs_q <= ofs;
          pcnt  <= P_LOAD;
        end else if (pcnt != '0) begin
          pcnt <= pcnt - 1'b1;
        end
      end else begin
        loaded <= 1'b0;
      end
      if (wr_evt) begin
        if (!cmd_q) begin
          cmd_q <= (dq_in[7:0] == SET_CODE);
        end else begin
          cmd_q <= 1'b0;
          if (dq_in[7:0] == CONF_CODE) mode8 <= addr[0];
        end
      end
    end
  end

  // R8
  ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) ce_n |=> !loaded);
  // R3
  sense_delay_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(loaded) |-> icnt == I_LOAD);
  // R9
  conf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && cmd_q && dq_in[7:0] == CONF_CODE |=> mode8 == $past(addr[0]));
  // R10
  mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mode8) |-> $past(wr_evt));
  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && $past(dq_oe) && $stable(addr) && $stable(bus16) |-> $stable(dq_out));
endmodule

// File: tb/test_pflash_page_reader.sv
module test_pflash_page_reader;
  localparam int INIT = 8;
  localparam int PAGE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce_n = 1'b0, oe_n = 1'b0, we_n = 1'b1, bus16 = 1'b1;
  logic [15:0] addr = '0, dq_in = '0, dq_out;
  logic dq_oe;
  int checks = 0, errs = 0;

  always #2 clk = ~clk;

  pflash_page_reader i_pflash_page_reader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .bus16(bus16),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  // {address, new_page}: new_page=1 expects INIT delay, 0 expects PAGE delay (4-word, 16-bit)
  localparam logic [16:0] VEC [9] = '{
    {16'h0010, 1'b1}, {16'h0014, 1'b0}, {16'h0012, 1'b0}, {16'h0016, 1'b0},
    {16'h0010, 1'b0}, {16'h0018, 1'b1}, {16'h001E, 1'b0}, {16'h0120, 1'b1},
    {16'h0122, 1'b0}};

  function automatic logic [15:0] expect_dq(input logic [15:0] a, input logic w16);
    logic [7:0] k;
    logic [15:0] w;
    k = a[8:1];
    w = {k ^ 8'hC3, k};
    if (w16) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input int n);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (n - 1) @(posedge clk);
    #1 check({req, " early"}, {15'd0, dq_oe}, 16'd0);
    @(posedge clk);
    #1 check({req, " oe"}, {15'd0, dq_oe}, 16'd1);
    check({req, " data"}, dq_out, expect_dq(a, bus16));
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq_in = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    // R2: outputs off while reset is held, even with enables active
    repeat (3) @(posedge clk);
    #1 check("R2 oe", {15'd0, dq_oe}, 16'd0);
    check("R2 data", dq_out, 16'd0);
    @(negedge clk);
    ce_n = 1'b1; rst_n = 1'b1;

    // R3 R4 R5 R7: table walk in 4-word, 16-bit mode
    foreach (VEC[i]) begin
      do_read(VEC[i][0] ? "R3 R5 R7 table" : "R4 R5 table", VEC[i][16:1], VEC[i][0] ? INIT : PAGE);
    end

    // R5: A0 ignored on the 16-bit bus
    @(negedge clk);
    addr = 16'h0123;
    #1 check("R5 a0 ignored", dq_out, expect_dq(16'h0122, 1'b1));

    // R1: oe_n alone gates output, return is immediate
    @(negedge clk);
    oe_n = 1'b1;
    #1 check("R1 oe off", {15'd0, dq_oe}, 16'd0);
    check("R1 data zero", dq_out, 16'd0);
    @(negedge clk);
    oe_n = 1'b0;
    #1 check("R1 oe back", {15'd0, dq_oe}, 16'd1);
    check("R1 data back", dq_out, expect_dq(16'h0122, 1'b1));

    // R8: chip enable toggle forces a full delay for the same address
    @(negedge clk);
    ce_n = 1'b1;
    #1 check("R1 ce off", {15'd0, dq_oe}, 16'd0);
    do_read("R8 ce toggle", 16'h0122, INIT);

    // R6: 8-bit bus
    @(negedge clk);
    ce_n = 1'b1; bus16 = 1'b0;
    do_read("R6 high byte", 16'h0041, INIT);
    do_read("R6 low byte", 16'h0040, PAGE);
    do_read("R6 other word", 16'h0045, PAGE);
    @(negedge clk);
    ce_n = 1'b1; bus16 = 1'b1;

    // R9: select 8-word page
    do_write(16'h0000, 16'h005A);
    do_write(16'h0001, 16'h00C9);
    do_read("R9 R7 open", 16'h0030, INIT);
    do_read("R7 a3 in page", 16'h0038, PAGE);
    do_read("R7 word 7", 16'h003E, PAGE);
    do_read("R7 back", 16'h0032, PAGE);

    // R10: wrong confirm code leaves 8-word mode
    do_write(16'h0000, 16'h005A);
    do_write(16'h0000, 16'h0000);
    do_read("R10 open", 16'h0050, INIT);
    do_read("R10 still 8-word", 16'h0058, PAGE);

    // R9: back to 4-word
    do_write(16'h0000, 16'h005A);
    do_write(16'h0000, 16'h00C9);
    do_read("R9 open", 16'h0060, INIT);
    do_read("R9 4-word a3 new page", 16'h0068, INIT);

    // R11: reset restores 4-word
    do_write(16'h0000, 16'h005A);
    do_write(16'h0001, 16'h00C9);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R2 reset mid-run", {15'd0, dq_oe}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    do_read("R11 open", 16'h0070, INIT);
    do_read("R11 4-word a3 new page", 16'h0078, INIT);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule